// File: doc/BRIEF.md
# Cascaded Two-Group DMA Request Arbiter

This block chooses which of eight DMA channels may use the bus. The channels form two groups of four. The lower group (channels 0 to 3) does not reach the bus directly. It competes inside the upper group as one channel, channel 4. Each group has its own arbiter. Software sets each arbiter to fixed or rotating priority with a write-only command byte, and can disable it. A channel's request is the OR of its hardware request line and its software request bit.

When a channel wins, its grant is held until its request goes away or it signals terminal count. Arbitration then runs again one cycle later. While the upper arbiter serves channel 4, the active-channel output reports the lower group's winner. Each group also has a read-only status byte. The upper nibble shows pending requests. The lower nibble shows terminal-count flags, which stay set until the status byte is read.

Top module: `dma_casc_arb`

## Requirements
- R1: After reset, both grants are 0, `act_valid` is 0, all terminal-count flags are 0, and both groups are enabled in fixed priority.
- R2: A command write stores bit 4 as the priority mode (0 fixed, 1 rotating) and bit 2 as the group disable (0 enabled, 1 disabled). The other bits have no effect. The two groups are configured independently.
- R3: A grant is issued only to a channel whose request was pending at the edge that issued it. In fixed mode, the lowest-numbered pending channel of the group wins.
- R4: In rotating mode, priority starts at the channel after the one granted most recently and wraps around, so the last-served channel ranks lowest. The pointer resets to the highest channel, which makes the first rotating order 0, 1, 2, 3.
- R5: A grant stays unchanged while the served channel keeps requesting and gives no terminal-count pulse. When the request drops or terminal count is signalled, the grant clears at that edge, and a new winner can be chosen one edge later.
- R6: In the upper group, channel 4 requests whenever any enabled lower-group channel requests. Channel 4 is released once no lower-group channel requests. A terminal-count pulse on channel 4 does not release it.
- R7: A disabled group issues no grants. Disabling the upper group also disables the lower group. Two edges after the disable write, both grants and `act_valid` are 0.
- R8: Status bits 7:4 show the raw pending request of the group's channels, lowest channel in bit 4. The pending bit of channel 4 (upper status bit 4) is the OR of the requests of channels 0 to 3. These bits do not depend on the enables.
- R9: Status bits 3:0 latch terminal-count pulses, lowest channel in bit 0. A read strobe clears them at the edge. A pulse that arrives in the same cycle as the read stays set. Upper status bit 0 (channel 4) always reads 0.
- R10: Each group's grant vector has at most one bit set.
- R11: `act_valid` is 1 when the upper arbiter grants channel 5, 6 or 7, with `act_chan` giving that channel number. It is also 1 when the upper arbiter grants channel 4 and the lower arbiter holds a grant, with `act_chan` giving the lower channel (0 to 3). Otherwise `act_valid` is 0 and `act_chan` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_lo | input | 1 | Command write strobe, lower group |
| cmd_wr_hi | input | 1 | Command write strobe, upper group |
| cmd_data | input | 8 | Command byte (bit 4 mode, bit 2 disable) |
| stat_rd_lo | input | 1 | Status read strobe, lower group (clears its TC flags) |
| stat_rd_hi | input | 1 | Status read strobe, upper group (clears its TC flags) |
| hw_req | input | 8 | Hardware request per channel |
| sw_req | input | 8 | Software request per channel |
| tc_pulse | input | 8 | Terminal-count pulse per channel |
| grant_lo | output | 4 | One-hot grant of the lower arbiter |
| grant_hi | output | 4 | One-hot grant of the upper arbiter (bit 0 is channel 4) |
| stat_lo | output | 8 | Lower group status: requests 7:4, TC flags 3:0 |
| stat_hi | output | 8 | Upper group status: requests 7:4, TC flags 3:0 |
| act_valid | output | 1 | A channel currently owns the bus |
| act_chan | output | 3 | Number of the channel that owns the bus |

## Verification
The properties assume that every input is synchronous to the clock and changes only between edges, so a request seen at an edge is the request that led to the grant. The bench meets this by driving all inputs on the falling edge. The read-clear property assumes no terminal-count pulse arrives in the same cycle as the read, so it is conditioned on that and makes no claim otherwise. The random stimulus still produces such coincidences, and the bench's reference model checks them. The disable property assumes the disable is held for two cycles. Disable writes in the stimulus persist until the next write to that group.

// File: rtl/dma_casc_pkg.sv
package dma_casc_pkg;

   typedef struct packed {
      logic rot;
      logic dis;
   } grp_cfg_t;

   localparam grp_cfg_t CFG_RESET = '{rot: 1'b0, dis: 1'b0};

endpackage

// File: rtl/dma_grp_cfg.sv
module dma_grp_cfg
   import dma_casc_pkg::*;
#(
   parameter int unsigned CMD_W    = 8,
   parameter int unsigned MODE_BIT = 4,
   parameter int unsigned DIS_BIT  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CMD_W-1:0] data_i,
   output grp_cfg_t         cfg_o
);

   initial begin
      assert (MODE_BIT < CMD_W && DIS_BIT < CMD_W) else $error("command field outside byte");
      assert (MODE_BIT != DIS_BIT) else $error("command fields overlap");
   end

   grp_cfg_t cfg_q;

   // reserved bits are folded away so they touch nothing
   logic unused_rsvd;
   assign unused_rsvd = ^data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
      end else if (wr_i) begin
         cfg_q.rot <= data_i[MODE_BIT];
         cfg_q.dis <= data_i[DIS_BIT];
      end
   end

   assign cfg_o = cfg_q;

endmodule

// File: rtl/dma_grp_arb.sv
module dma_grp_arb #(
   parameter  int unsigned N  = 4,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rot_i,
   input  logic [N-1:0]  pend_i,
   input  logic [N-1:0]  done_i,
   output logic [N-1:0]  gnt_o,
   output logic [IW-1:0] idx_o,
   output logic          vld_o
);

   initial begin
      assert (N >= 2 && (1 << IW) == N) else $error("group size must be a power of two");
   end

   logic          busy_q;
   logic [IW-1:0] idx_q;
   logic [IW-1:0] ptr_q;
   logic          found;
   logic [IW-1:0] win;
   logic          release_now;

   // candidate order: fixed starts at 0, rotating starts after the pointer
   logic [N-1:0][IW-1:0] cand;
   genvar k;
   generate
      for (k = 0; k < N; k++) begin : g_cand
         assign cand[k] = rot_i ? IW'(int'(ptr_q) + k + 1) : IW'(k);
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int j = 0; j < N; j++) begin
         if (!found && pend_i[cand[j]]) begin
            found = 1'b1;
            win   = cand[j];
         end
      end
   end

   assign release_now = busy_q && (!pend_i[idx_q] || done_i[idx_q]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         ptr_q  <= IW'(N - 1);
      end else if (busy_q) begin
         if (release_now) begin
            busy_q <= 1'b0;
         end
      end else if (found) begin
         busy_q <= 1'b1;
         idx_q  <= win;
         ptr_q  <= win;
      end
   end

   genvar c;
   generate
      for (c = 0; c < N; c++) begin : g_onehot
         assign gnt_o[c] = busy_q && (idx_q == IW'(c));
      end
   endgenerate

   assign idx_o = idx_q;
   assign vld_o = busy_q;

endmodule

// File: rtl/dma_grp_stat.sv
module dma_grp_stat #(
   parameter int unsigned N       = 4,
   parameter logic [N-1:0] TC_MASK = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rd_i,
   input  logic [N-1:0]   req_i,
   input  logic [N-1:0]   tc_i,
   output logic [2*N-1:0] stat_o
);

   logic [N-1:0] tc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q <= '0;
      end else begin
         tc_q <= tc_i | (tc_q & {N{~rd_i}});
      end
   end

   assign stat_o = {req_i, tc_q & TC_MASK};

endmodule

// File: rtl/dma_casc_arb.sv
module dma_casc_arb
   import dma_casc_pkg::*;
#(
   parameter  int unsigned GRP_CH   = 4,
   parameter  int unsigned CMD_W    = 8,
   parameter  int unsigned MODE_BIT = 4,
   parameter  int unsigned DIS_BIT  = 2,
   localparam int unsigned IW       = $clog2(GRP_CH),
   localparam int unsigned ALL_CH   = 2 * GRP_CH,
   localparam int unsigned CH_W     = IW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_lo,
   input  logic              cmd_wr_hi,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic              stat_rd_lo,
   input  logic              stat_rd_hi,
   input  logic [ALL_CH-1:0] hw_req,
   input  logic [ALL_CH-1:0] sw_req,
   input  logic [ALL_CH-1:0] tc_pulse,
   output logic [GRP_CH-1:0] grant_lo,
   output logic [GRP_CH-1:0] grant_hi,
   output logic [ALL_CH-1:0] stat_lo,
   output logic [ALL_CH-1:0] stat_hi,
   output logic              act_valid,
   output logic [CH_W-1:0]   act_chan
);

   initial begin
      assert (GRP_CH >= 2) else $error("group too small");
      assert (ALL_CH <= CMD_W) else $error("status does not fit the register width");
   end

   // index 0 is the lower group, index 1 the upper group
   logic [ALL_CH-1:0]            req;
   grp_cfg_t                     cfg    [2];
   logic [1:0]                   wr_s;
   logic [1:0]                   rd_s;
   logic [1:0][GRP_CH-1:0]       pend;
   logic [1:0][GRP_CH-1:0]       done;
   logic [1:0][GRP_CH-1:0]       st_req;
   logic [1:0][GRP_CH-1:0]       st_tc;
   logic [1:0][GRP_CH-1:0]       gnt;
   logic [1:0][IW-1:0]           idx;
   logic [1:0]                   vld;
   logic [1:0][ALL_CH-1:0]       stat;
   logic                         en_hi;
   logic                         en_lo;
   logic                         casc_req;

   assign req  = hw_req | sw_req;
   assign wr_s = {cmd_wr_hi, cmd_wr_lo};
   assign rd_s = {stat_rd_hi, stat_rd_lo};

   assign en_hi    = ~cfg[1].dis;
   assign en_lo    = en_hi & ~cfg[0].dis;
   assign pend[0]  = req[GRP_CH-1:0] & {GRP_CH{en_lo}};
   assign casc_req = |pend[0];
   assign pend[1]  = {req[ALL_CH-1:GRP_CH+1], casc_req} & {GRP_CH{en_hi}};

   assign done[0]  = tc_pulse[GRP_CH-1:0];
   assign done[1]  = {tc_pulse[ALL_CH-1:GRP_CH+1], 1'b0};

   assign st_req[0] = req[GRP_CH-1:0];
   assign st_req[1] = {req[ALL_CH-1:GRP_CH+1], |req[GRP_CH-1:0]};
   assign st_tc[0]  = tc_pulse[GRP_CH-1:0];
   assign st_tc[1]  = tc_pulse[ALL_CH-1:GRP_CH];

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_grp
         localparam logic [GRP_CH-1:0] MASK = (g == 1) ? ~GRP_CH'(1) : '1;

         dma_grp_cfg #(
            .CMD_W   (CMD_W),
            .MODE_BIT(MODE_BIT),
            .DIS_BIT (DIS_BIT)
         ) u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_i  (wr_s[g]),
            .data_i(cmd_data),
            .cfg_o (cfg[g])
         );

         dma_grp_arb #(
            .N(GRP_CH)
         ) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .rot_i (cfg[g].rot),
            .pend_i(pend[g]),
            .done_i(done[g]),
            .gnt_o (gnt[g]),
            .idx_o (idx[g]),
            .vld_o (vld[g])
         );

         dma_grp_stat #(
            .N      (GRP_CH),
            .TC_MASK(MASK)
         ) u_stat (
            .clk   (clk),
            .rst_n (rst_n),
            .rd_i  (rd_s[g]),
            .req_i (st_req[g]),
            .tc_i  (st_tc[g]),
            .stat_o(stat[g])
         );
      end
   endgenerate

   assign grant_lo = gnt[0];
   assign grant_hi = gnt[1];
   assign stat_lo  = stat[0];
   assign stat_hi  = stat[1];

   // the cascade slot passes the lower winner through
   always_comb begin
      act_valid = 1'b0;
      act_chan  = '0;
      if (vld[1]) begin
         if (idx[1] != '0) begin
            act_valid = 1'b1;
            act_chan  = {1'b1, idx[1]};
         end else if (vld[0]) begin
            act_valid = 1'b1;
            act_chan  = {1'b0, idx[0]};
         end
      end
   end

endmodule

// File: rtl/dma_casc_arb_chk.sv
module dma_casc_arb_chk #(
   parameter int unsigned N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en_hi,
   input logic [N-1:0] req_lo,
   input logic [N-1:0] tc_lo,
   input logic         stat_rd_lo,
   input logic [N-1:0] grant_lo,
   input logic [N-1:0] grant_hi,
   input logic [N-1:0] stat_tc_lo,
   input logic         act_valid
);

   AST_GNT_ONEHOT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_lo)); // R10
   AST_GNT_ONEHOT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_hi)); // R10
   AST_GNT_HOLD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_lo != '0) |=> (grant_lo == '0 || grant_lo == $past(grant_lo))); // R5
   AST_GNT_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_hi != '0) |=> (grant_hi == '0 || grant_hi == $past(grant_hi))); // R5
   AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_lo != '0 && $past(grant_lo) == '0) |-> (($past(req_lo) & grant_lo) != '0)); // R3
   AST_CASC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_hi[0] && req_lo == '0) |=> !grant_hi[0]); // R6
   AST_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_hi && $past(!en_hi)) |-> (grant_lo == '0 && grant_hi == '0 && !act_valid)); // R7
   AST_TC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_lo != '0) |=> ((stat_tc_lo & $past(tc_lo)) == $past(tc_lo))); // R9
   AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_lo && tc_lo == '0) |=> (stat_tc_lo == '0)); // R9

endmodule

bind dma_casc_arb dma_casc_arb_chk #(.N(GRP_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_hi     (en_hi),
   .req_lo    (hw_req[GRP_CH-1:0] | sw_req[GRP_CH-1:0]),
   .tc_lo     (tc_pulse[GRP_CH-1:0]),
   .stat_rd_lo(stat_rd_lo),
   .grant_lo  (grant_lo),
   .grant_hi  (grant_hi),
   .stat_tc_lo(stat_lo[GRP_CH-1:0]),
   .act_valid (act_valid)
);

// File: tb/dma_casc_arb_bench.sv
module dma_casc_arb_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr_lo = 1'b0, cmd_wr_hi = 1'b0;
   logic [7:0] cmd_data = '0;
   logic       stat_rd_lo = 1'b0, stat_rd_hi = 1'b0;
   logic [7:0] hw_req = '0, sw_req = '0, tc_pulse = '0;
   logic [3:0] grant_lo, grant_hi;
   logic [7:0] stat_lo, stat_hi;
   logic       act_valid;
   logic [2:0] act_chan;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   dma_casc_arb u_dma_casc_arb (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr_lo(cmd_wr_lo), .cmd_wr_hi(cmd_wr_hi), .cmd_data(cmd_data),
      .stat_rd_lo(stat_rd_lo), .stat_rd_hi(stat_rd_hi),
      .hw_req(hw_req), .sw_req(sw_req), .tc_pulse(tc_pulse),
      .grant_lo(grant_lo), .grant_hi(grant_hi),
      .stat_lo(stat_lo), .stat_hi(stat_hi),
      .act_valid(act_valid), .act_chan(act_chan)
   );

   task automatic check_eq(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int m_gnt[2] = '{-1, -1};
   int m_ptr[2] = '{3, 3};
   bit m_rot[2] = '{0, 0};
   bit m_dis[2] = '{0, 0};
   bit m_tc[8]  = '{default: 0};

   function automatic logic [3:0] as_onehot(input int i);
      return (i < 0) ? 4'b0000 : 4'(1 << i);
   endfunction

   task automatic model_step();
      bit r[8];
      bit p[2][4];
      bit d[2][4];
      bit any_lo;
      int idx;
      for (int i = 0; i < 8; i++) r[i] = hw_req[i] | sw_req[i];
      any_lo = 0;
      for (int i = 0; i < 4; i++) begin
         p[0][i] = r[i] && !m_dis[1] && !m_dis[0];
         d[0][i] = tc_pulse[i];
         if (p[0][i]) any_lo = 1;
      end
      p[1][0] = any_lo && !m_dis[1];
      d[1][0] = 0;
      for (int j = 1; j < 4; j++) begin
         p[1][j] = r[4+j] && !m_dis[1];
         d[1][j] = tc_pulse[4+j];
      end
      for (int g = 0; g < 2; g++) begin
         if (m_gnt[g] >= 0) begin
            if (!p[g][m_gnt[g]] || d[g][m_gnt[g]]) m_gnt[g] = -1;
         end else begin
            for (int k = 0; k < 4; k++) begin
               idx = m_rot[g] ? (m_ptr[g] + 1 + k) % 4 : k;
               if (p[g][idx]) begin
                  m_gnt[g] = idx;
                  m_ptr[g] = idx;
                  break;
               end
            end
         end
      end
      for (int i = 0; i < 8; i++)
         m_tc[i] = tc_pulse[i] || (m_tc[i] && !((i < 4) ? stat_rd_lo : stat_rd_hi));
      if (cmd_wr_lo) begin m_rot[0] = cmd_data[4]; m_dis[0] = cmd_data[2]; end
      if (cmd_wr_hi) begin m_rot[1] = cmd_data[4]; m_dis[1] = cmd_data[2]; end
   endtask

   task automatic model_compare();
      logic [7:0] r;
      logic [7:0] e_lo, e_hi;
      logic       e_v;
      logic [2:0] e_c;
      r = hw_req | sw_req;
      e_lo = {r[3:0], 4'(m_tc[3]), 4'(m_tc[2]), 4'(m_tc[1]), 4'(m_tc[0])} ;
      e_lo = {r[3:0], m_tc[3], m_tc[2], m_tc[1], m_tc[0]};
      e_hi = {r[7:5], |r[3:0], m_tc[7], m_tc[6], m_tc[5], 1'b0};
      e_v = 0; e_c = 0;
      if (m_gnt[1] > 0) begin e_v = 1; e_c = 3'(4 + m_gnt[1]); end
      else if (m_gnt[1] == 0 && m_gnt[0] >= 0) begin e_v = 1; e_c = 3'(m_gnt[0]); end
      check_eq("R3/R4/R5", "grant_lo", 32'(grant_lo), 32'(as_onehot(m_gnt[0])));
      check_eq("R6", "grant_hi", 32'(grant_hi), 32'(as_onehot(m_gnt[1])));
      check_eq("R8", "stat_lo req", 32'(stat_lo[7:4]), 32'(e_lo[7:4]));
      check_eq("R8", "stat_hi req", 32'(stat_hi[7:4]), 32'(e_hi[7:4]));
      check_eq("R9", "stat_lo tc", 32'(stat_lo[3:0]), 32'(e_lo[3:0]));
      check_eq("R9", "stat_hi tc", 32'(stat_hi[3:0]), 32'(e_hi[3:0]));
      check_eq("R11", "act_valid", 32'(act_valid), 32'(e_v));
      check_eq("R11", "act_chan", 32'(act_chan), 32'(e_c));
      check_eq("R10", "onehot", 32'(($countones(grant_lo) <= 1) && ($countones(grant_hi) <= 1)), 32'(1));
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_gnt = '{-1, -1}; m_ptr = '{3, 3};
         m_rot = '{0, 0};   m_dis = '{0, 0};
         m_tc  = '{default: 0};
      end else begin
         model_step();
      end
      #5;
      if (rst_n) model_compare();
   end

   // ---------------- stimulus ----------------
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check_eq("R1", "grant_lo", 32'(grant_lo), 0);
      check_eq("R1", "grant_hi", 32'(grant_hi), 0);
      check_eq("R1", "act_valid", 32'(act_valid), 0);
      check_eq("R1", "tc flags", 32'({stat_lo[3:0], stat_hi[3:0]}), 0);

      // R3: fixed priority, lowest pending wins; cascade carries it
      hw_req = 8'h0A;
      tick();
      check_eq("R3", "grant_lo fixed", 32'(grant_lo), 32'h2);
      check_eq("R6", "grant_hi cascade", 32'(grant_hi), 32'h1);
      check_eq("R11", "act_chan lower", 32'({act_valid, act_chan}), 32'h9);

      // R5: terminal count releases; R6 cascade stays held
      tc_pulse = 8'h02;
      tick();
      tc_pulse = 8'h00;
      check_eq("R5", "grant_lo released", 32'(grant_lo), 0);
      check_eq("R6", "grant_hi held", 32'(grant_hi), 32'h1);
      check_eq("R11", "act_valid gap", 32'(act_valid), 0);
      tick();
      check_eq("R3", "grant_lo regrant", 32'(grant_lo), 32'h2);

      // R2/R4: switch lower group to rotating
      cmd_wr_lo = 1'b1; cmd_data = 8'h10; tc_pulse = 8'h02;
      tick();
      cmd_wr_lo = 1'b0; cmd_data = 8'h00; tc_pulse = 8'h00;
      tick();
      check_eq("R2/R4", "grant_lo rotated", 32'(grant_lo), 32'h8);

      // R9: sticky TC flag, cleared by read; R8 request bits
      check_eq("R9", "stat_lo before read", 32'(stat_lo), 32'hA2);
      check_eq("R8", "stat_hi cascade bit", 32'(stat_hi), 32'h10);
      stat_rd_lo = 1'b1;
      tick();
      stat_rd_lo = 1'b0;
      check_eq("R9", "stat_lo after read", 32'(stat_lo), 32'hA0);

      // R7: upper disable shuts both groups
      cmd_wr_hi = 1'b1; cmd_data = 8'h04;
      tick();
      cmd_wr_hi = 1'b0; cmd_data = 8'h00;
      tick();
      check_eq("R7", "grants off", 32'({grant_hi, grant_lo}), 0);
      check_eq("R7", "act off", 32'(act_valid), 0);
      check_eq("R8", "status ignores enable", 32'(stat_hi), 32'h10);
      cmd_wr_hi = 1'b1; cmd_data = 8'hEB;   // reserved bits set, mode/disable clear
      tick();
      cmd_wr_hi = 1'b0; cmd_data = 8'h00;

      // R6: cascade against channel 5 in fixed upper mode
      hw_req = 8'h2A;
      tick();
      check_eq("R6", "cascade wins", 32'(grant_hi), 32'h1);
      check_eq("R4", "rotating from top", 32'(grant_lo), 32'h2);
      hw_req = 8'h20;
      tick();
      tick();
      check_eq("R6", "channel 5 granted", 32'(grant_hi), 32'h2);
      check_eq("R11", "act_chan upper", 32'({act_valid, act_chan}), 32'hD);
      tick();
      tick();
      check_eq("R5", "grant held", 32'(grant_hi), 32'h2);
      tc_pulse = 8'h20;
      tick();
      tc_pulse = 8'h00;
      check_eq("R5", "tc release hi", 32'(grant_hi), 0);

      // random traffic, compared against the model every cycle
      for (int n = 0; n < 4000; n++) begin
         for (int b = 0; b < 8; b++) begin
            if ($urandom_range(7) == 0) hw_req[b] = ~hw_req[b];
            if ($urandom_range(31) == 0) sw_req[b] = ~sw_req[b];
            tc_pulse[b] = ($urandom_range(15) == 0);
         end
         cmd_wr_lo = ($urandom_range(39) == 0);
         cmd_wr_hi = ($urandom_range(39) == 0);
         cmd_data  = 8'($urandom);
         if ($urandom_range(2) != 0) cmd_data[2] = 1'b0;
         stat_rd_lo = ($urandom_range(7) == 0);
         stat_rd_hi = ($urandom_range(7) == 0);
         tick();
      end
      cmd_wr_lo = 1'b0; cmd_wr_hi = 1'b0; stat_rd_lo = 1'b0; stat_rd_hi = 1'b0;
      tick();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule